// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host-side register port and a modelled PCI target. The host reaches configuration space through a 64 KB window. It selects the target bus by writing a 4-bit field into a control/status register. Each word access to the window becomes one configuration cycle request. The request carries the bus number, device, function and dword register index decoded from the window offset. It also carries the cycle type and, for bus 0, a one-hot IDSEL line in the AD16..AD31 range.

Data is byte-swapped in both directions, because the host side is big-endian and the PCI side is little-endian. When the target signals a master abort, or does not answer within a bounded number of cycles, the access still completes. A read then returns all ones, and a sticky timeout flag is raised in the control/status register. Device numbers outside the supported range are answered locally and no cycle is issued. Only one access is in flight at a time, and the window port holds its ready signal low until the current access completes.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset the control/status register reads as only the host-slot strap at bit 13, the window port is ready, and no request or completion is signalled.
- R2: Control/status bits [26:23] hold the bus select last written and read back unchanged. Bit 13 always reflects the host-slot strap input and ignores writes. All bits other than 26:23, 13 and 8 read zero.
- R3: A window offset is decoded as device = [15:11], function = [10:8], register index = [7:2], and bits [1:0] have no effect.
- R4: With bus select 0, the request is type 0 (req_type1 = 0) and req_idsel has exactly bit N set for device N, where bit N stands for AD(16+N).
- R5: With a nonzero bus select, the request is type 1 (req_type1 = 1), req_idsel is zero, and req_bus carries the bus select.
- R6: A device number above 15 issues no request. The access completes one cycle after acceptance, a read returns 0xFFFFFFFF, and the timeout flag is unchanged.
- R7: Write data toward the target and read data back to the host are byte-reversed: byte 0 swaps with byte 3, and byte 1 swaps with byte 2.
- R8: A master abort response completes the access. A read then returns 0xFFFFFFFF, and for reads and writes alike bit 8 of the control/status register is set.
- R9: If no response arrives, the access completes as a master abort exactly TMO_CYCLES cycles after the request is raised.
- R10: Bit 8 stays set until a control/status write with bit 8 = 1 clears it. A write with bit 8 = 0 leaves it set. If an abort and a clearing write land in the same cycle, the flag ends up set.
- R11: From acceptance until completion, win_ready is low, window requests are ignored, and the request fields hold steady even if the bus select is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_slot | input | 1 | Strap: bridge sits in the host system slot |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 32 | Control/status write data |
| csr_rdata | output | 32 | Control/status read value |
| win_valid | input | 1 | Window access request |
| win_write | input | 1 | 1 = write, 0 = read |
| win_addr | input | 16 | Offset within the configuration window |
| win_wdata | input | 32 | Host-order write data |
| win_ready | output | 1 | Window port can accept an access |
| win_done | output | 1 | One-cycle completion pulse |
| win_rdata | output | 32 | Host-order read data, valid with win_done |
| req_valid | output | 1 | Configuration cycle request toward the target |
| req_write | output | 1 | Request is a write |
| req_type1 | output | 1 | 1 = type 1 cycle, 0 = type 0 cycle |
| req_bus | output | 4 | Bus number |
| req_dev | output | 5 | Device number |
| req_func | output | 3 | Function number |
| req_reg | output | 6 | Dword register index |
| req_idsel | output | 16 | One-hot IDSEL, bit N = AD(16+N) |
| req_wdata | output | 32 | PCI-order write data |
| rsp_valid | input | 1 | Target response |
| rsp_abort | input | 1 | Response is a master abort |
| rsp_rdata | input | 32 | PCI-order read data |

## Verification
Two functions can fall in the same cycle. One is raising the sticky timeout flag when an abort completes an access. The other is software clearing that flag through a control/status write. The bench clears the flag first, then drives the abort response and a write-1-to-clear on the same clock edge. It judges the result by reading the register afterwards and expecting bit 8 set. A second overlap is a bus-select rewrite and a stray window request while an access is outstanding. These are judged by checking that the in-flight request fields stay unchanged and that no second request appears.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} pcx_state_t;

  localparam int CSR_W      = 32;
  localparam int BUS_W      = 4;
  localparam int BUS_LSB    = 23;
  localparam int TMO_BIT    = 8;
  localparam int HOST_BIT   = 13;
  localparam int DEV_W      = 5;
  localparam int FUNC_W     = 3;
  localparam int REG_W      = 6;
  localparam int OFF_W      = 16;
endpackage

// File: rtl/pcx_decode.sv
module pcx_decode
  import pcx_pkg::*;
#(
  parameter int IDSEL_W = 16
) (
  input  logic [BUS_W-1:0]   bus_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [DEV_W-1:0]   dev_o,
  output logic [FUNC_W-1:0]  func_o,
  output logic [REG_W-1:0]   reg_o,
  output logic               type1_o,
  output logic               in_range_o,
  output logic [IDSEL_W-1:0] idsel_o
);
  assign dev_o      = off_i[15:11];
  assign func_o     = off_i[10:8];
  assign reg_o      = off_i[7:2];
  assign type1_o    = (bus_i != '0);
  assign in_range_o = (int'(dev_o) < IDSEL_W);

  // one IDSEL line per supported slot, only driven for type 0 cycles
  for (genvar i = 0; i < IDSEL_W; i++) begin : g_idsel
    assign idsel_o[i] = !type1_o && (int'(dev_o) == i);
  end
endmodule

// File: rtl/pcx_swap.sv
module pcx_swap #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] d_i,
  output logic [8*BYTES-1:0] d_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign d_o[8*b +: 8] = d_i[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/pcx_csr.sv
module pcx_csr
  import pcx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             host_slot,
  input  logic             set_tmo,
  output logic [CSR_W-1:0] rdata,
  output logic [BUS_W-1:0] bus_sel,
  output logic             tmo_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_sel  <= '0;
      tmo_flag <= 1'b0;
    end else begin
      if (we) bus_sel <= wdata[BUS_LSB +: BUS_W];
      if (set_tmo)                 tmo_flag <= 1'b1;
      else if (we && wdata[TMO_BIT]) tmo_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[BUS_LSB +: BUS_W] = bus_sel;
    rdata[HOST_BIT]         = host_slot;
    rdata[TMO_BIT]          = tmo_flag;
  end

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    tmo_flag && !(we && wdata[TMO_BIT]) |=> tmo_flag);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_tmo |=> tmo_flag);
  a_r2_bus_write: assert property (@(posedge clk) disable iff (rst)
    we |=> bus_sel == $past(wdata[BUS_LSB +: BUS_W]));
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pcx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDSEL_W    = 16,
  parameter int TMO_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_slot,
  input  logic               csr_we,
  input  logic [CSR_W-1:0]   csr_wdata,
  output logic [CSR_W-1:0]   csr_rdata,
  input  logic               win_valid,
  input  logic               win_write,
  input  logic [OFF_W-1:0]   win_addr,
  input  logic [DATA_W-1:0]  win_wdata,
  output logic               win_ready,
  output logic               win_done,
  output logic [DATA_W-1:0]  win_rdata,
  output logic               req_valid,
  output logic               req_write,
  output logic               req_type1,
  output logic [BUS_W-1:0]   req_bus,
  output logic [DEV_W-1:0]   req_dev,
  output logic [FUNC_W-1:0]  req_func,
  output logic [REG_W-1:0]   req_reg,
  output logic [IDSEL_W-1:0] req_idsel,
  output logic [DATA_W-1:0]  req_wdata,
  input  logic               rsp_valid,
  input  logic               rsp_abort,
  input  logic [DATA_W-1:0]  rsp_rdata
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  pcx_state_t          state;
  logic [CNT_W-1:0]    cnt;
  logic [BUS_W-1:0]    bus_sel;
  logic                tmo_flag;
  logic                set_tmo;
  logic                finish;
  logic                abort_now;

  logic [DEV_W-1:0]    d_dev;
  logic [FUNC_W-1:0]   d_func;
  logic [REG_W-1:0]    d_reg;
  logic                d_type1;
  logic                d_in_range;
  logic [IDSEL_W-1:0]  d_idsel;
  logic [DATA_W-1:0]   wdata_sw;
  logic [DATA_W-1:0]   rdata_sw;

  pcx_csr u_csr (
    .clk      (clk),
    .rst      (rst),
    .we       (csr_we),
    .wdata    (csr_wdata),
    .host_slot(host_slot),
    .set_tmo  (set_tmo),
    .rdata    (csr_rdata),
    .bus_sel  (bus_sel),
    .tmo_flag (tmo_flag)
  );

  pcx_decode #(.IDSEL_W(IDSEL_W)) u_dec (
    .bus_i     (bus_sel),
    .off_i     (win_addr),
    .dev_o     (d_dev),
    .func_o    (d_func),
    .reg_o     (d_reg),
    .type1_o   (d_type1),
    .in_range_o(d_in_range),
    .idsel_o   (d_idsel)
  );

  pcx_swap #(.BYTES(DATA_W/8)) u_swap_wr (.d_i(win_wdata), .d_o(wdata_sw));
  pcx_swap #(.BYTES(DATA_W/8)) u_swap_rd (.d_i(rsp_rdata), .d_o(rdata_sw));

  assign finish    = (state == ST_WAIT) && (rsp_valid || cnt == CNT_LAST);
  assign abort_now = rsp_valid ? rsp_abort : 1'b1;
  assign set_tmo   = finish && abort_now;
  assign win_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      win_done  <= 1'b0;
      win_rdata <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_type1 <= 1'b0;
      req_bus   <= '0;
      req_dev   <= '0;
      req_func  <= '0;
      req_reg   <= '0;
      req_idsel <= '0;
      req_wdata <= '0;
    end else begin
      win_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (win_valid) begin
            if (!d_in_range) begin
              win_done  <= 1'b1;
              win_rdata <= '1;
            end else begin
              state     <= ST_WAIT;
              cnt       <= '0;
              req_valid <= 1'b1;
              req_write <= win_write;
              req_type1 <= d_type1;
              req_bus   <= bus_sel;
              req_dev   <= d_dev;
              req_func  <= d_func;
              req_reg   <= d_reg;
              req_idsel <= d_idsel;
              req_wdata <= wdata_sw;
            end
          end
        end
        ST_WAIT: begin
          if (finish) begin
            state     <= ST_IDLE;
            req_valid <= 1'b0;
            win_done  <= 1'b1;
            win_rdata <= abort_now ? '1 : rdata_sw;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_idsel_onehot: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_type1 |-> $countones(req_idsel) == 1);
  a_r5_type1_no_idsel: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_type1 |-> req_idsel == '0 && req_bus != '0);
  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !win_ready);
  a_r11_fields_stable: assert property (@(posedge clk) disable iff (rst)
    req_valid && $past(req_valid) |-> $stable(req_bus) && $stable(req_dev) && $stable(req_reg));
  a_r6_no_cycle_out_of_range: assert property (@(posedge clk) disable iff (rst)
    win_valid && win_ready && !d_in_range |=> !req_valid && win_done);
  a_r8_abort_sets_flag: assert property (@(posedge clk) disable iff (rst)
    req_valid && rsp_valid && rsp_abort |=> tmo_flag && win_done);
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT |-> cnt < CNT_W'(TMO_CYCLES));
endmodule

// File: tb/pci_cfg_xlate_bench.sv
module pci_cfg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic clk = 0;
  logic rst = 1;
  logic host_slot = 1;
  logic csr_we = 0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic win_valid = 0, win_write = 0;
  logic [15:0] win_addr = '0;
  logic [31:0] win_wdata = '0;
  logic win_ready, win_done;
  logic [31:0] win_rdata;
  logic req_valid, req_write, req_type1;
  logic [3:0] req_bus;
  logic [4:0] req_dev;
  logic [2:0] req_func;
  logic [5:0] req_reg;
  logic [15:0] req_idsel;
  logic [31:0] req_wdata;
  logic rsp_valid = 0, rsp_abort = 0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0, failures = 0;
  logic [3:0] cur_bus = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_xlate u_pci_cfg_xlate (
    .clk(clk), .rst(rst), .host_slot(host_slot),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .win_valid(win_valid), .win_write(win_write), .win_addr(win_addr),
    .win_wdata(win_wdata), .win_ready(win_ready), .win_done(win_done),
    .win_rdata(win_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_type1(req_type1), .req_bus(req_bus), .req_dev(req_dev),
    .req_func(req_func), .req_reg(req_reg), .req_idsel(req_idsel),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_abort(rsp_abort),
    .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] swp(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] pat(input logic [3:0] b, input logic [4:0] d,
                                      input logic [2:0] f, input logic [5:0] r);
    return 32'hC300_0000 | (32'(b) << 20) | (32'(d) << 15) | (32'(f) << 12) |
           (32'(r) << 6) | 32'h15;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk);
    csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0;
  endtask

  // kind: 0 = normal response, 1 = master abort, 2 = no response
  task automatic access(input logic wr, input logic [15:0] off, input logic [31:0] wd,
                        input int lat, input int kind, input logic col,
                        output logic [31:0] rd);
    logic [4:0] dv;
    logic [15:0] exp_idsel;
    int n;
    dv = off[15:11];
    @(negedge clk);
    win_valid = 1; win_write = wr; win_addr = off; win_wdata = wd;
    @(negedge clk);
    win_valid = 0;
    if (dv > 15) begin
      chk("R6 no request", 32'(req_valid), 0);
      chk("R6 done", 32'(win_done), 1);
      rd = win_rdata;
    end else begin
      exp_idsel = (cur_bus == 0) ? (16'd1 << dv) : 16'd0;
      chk("R11 ready low", 32'(win_ready), 0);
      chk("R3 req_valid", 32'(req_valid), 1);
      chk("R3 dev", 32'(req_dev), 32'(dv));
      chk("R3 func", 32'(req_func), 32'(off[10:8]));
      chk("R3 reg", 32'(req_reg), 32'(off[7:2]));
      chk("R5 bus", 32'(req_bus), 32'(cur_bus));
      chk("R4 R5 type", 32'(req_type1), 32'(cur_bus != 0));
      chk("R4 R5 idsel", 32'(req_idsel), 32'(exp_idsel));
      chk("R3 write flag", 32'(req_write), 32'(wr));
      if (wr) chk("R7 write swap", req_wdata, swp(wd));
      if (kind == 2) begin
        n = 0;
        while (!win_done && n < 100) begin
          @(negedge clk);
          n++;
        end
        chk("R9 timeout cycles", n, TMO);
      end else begin
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          win_valid = (i == 0);
          win_addr = 16'hFFFF;
          if (i == 0) begin csr_we = 1; csr_wdata = 32'h0780_0000 | (32'(cur_bus) << 23); end
          else csr_we = 0;
          chk("R11 no early done", 32'(win_done), 0);
        end
        win_valid = 0;
        if (lat > 0) begin
          // restore bus select that was disturbed during the wait
          csr_we = 1; csr_wdata = 32'(cur_bus) << 23;
          @(negedge clk);
          csr_we = 0;
          chk("R11 fields held", {req_bus, req_dev, req_reg}, {cur_bus, dv, off[7:2]});
        end
        rsp_valid = 1; rsp_abort = (kind == 1);
        rsp_rdata = pat(cur_bus, dv, off[10:8], off[7:2]);
        if (col) begin csr_we = 1; csr_wdata = (32'(cur_bus) << 23) | 32'h100; end
        @(negedge clk);
        rsp_valid = 0; rsp_abort = 0; csr_we = 0;
        chk("R11 done", 32'(win_done), 1);
        chk("R11 request dropped", 32'(req_valid), 0);
      end
      rd = win_rdata;
    end
    @(negedge clk);
    chk("R11 no stray request", 32'(req_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] off;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 csr reset", csr_rdata, 32'h0000_2000);
    chk("R1 ready", 32'(win_ready), 1);
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 done", 32'(win_done), 0);
    // R2
    csr_write(32'hFFFF_FEFF);
    chk("R2 csr fields", csr_rdata, 32'h0780_2000);
    host_slot = 0;
    #1 chk("R2 strap low", csr_rdata, 32'h0780_0000);
    host_slot = 1;
    // sweep all buses and device numbers
    for (int b = 0; b < 16; b++) begin
      cur_bus = 4'(b);
      csr_write(32'(b) << 23);
      chk("R2 bus readback", csr_rdata, (32'(b) << 23) | 32'h2000);
      for (int d = 0; d < 32; d++) begin
        off = {5'(d), 3'(d % 8), 6'((d * 5 + b) % 64), 2'(d % 4)};
        access(0, off, 32'h0, d % 3, 0, 0, rd);
        if (d > 15) chk("R6 all ones", rd, 32'hFFFF_FFFF);
        else chk("R7 read swap", rd, swp(pat(4'(b), 5'(d), off[10:8], off[7:2])));
      end
      chk("R6 flag unchanged", 32'(csr_rdata[8]), 0);
    end
    // writes on bus 0 and bus 3
    cur_bus = 0; csr_write(32'h0);
    access(1, 16'h2A14, 32'h1122_3344, 1, 0, 0, rd);
    cur_bus = 3; csr_write(32'h3 << 23);
    access(1, 16'h0908, 32'hA1B2_C3D4, 0, 0, 0, rd);
    // R8 read abort
    access(0, 16'h1810, 32'h0, 2, 1, 0, rd);
    chk("R8 abort data", rd, 32'hFFFF_FFFF);
    chk("R8 flag set", 32'(csr_rdata[8]), 1);
    // R10 write 0 keeps, write 1 clears
    csr_write(32'h3 << 23);
    chk("R10 flag kept", 32'(csr_rdata[8]), 1);
    csr_write((32'h3 << 23) | 32'h100);
    chk("R10 flag cleared", 32'(csr_rdata[8]), 0);
    // R8 write abort
    access(1, 16'h1004, 32'h5555_AAAA, 0, 1, 0, rd);
    chk("R8 write abort flag", 32'(csr_rdata[8]), 1);
    csr_write((32'h3 << 23) | 32'h100);
    // R9 silent target
    cur_bus = 0; csr_write(32'h100);
    access(0, 16'h7800, 32'h0, 0, 2, 0, rd);
    chk("R9 timeout data", rd, 32'hFFFF_FFFF);
    chk("R9 timeout flag", 32'(csr_rdata[8]), 1);
    csr_write(32'h100);
    chk("R10 cleared again", 32'(csr_rdata[8]), 0);
    // R10 set and clear in the same cycle
    access(0, 16'h3008, 32'h0, 1, 1, 1, rd);
    chk("R10 set wins", 32'(csr_rdata[8]), 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule